// File: doc/BRIEF.md
# MDIO Management Command Unit

This block lets a processor reach the management registers of external Ethernet PHYs. Software fills a small set of registers (a control word, a data word, an extended-address word and a 64-bit port mask) and sets one execute bit. The unit then generates the MDIO frames on its MDC/MDIO pins and clears the execute bit when it is finished. Software polls that bit.

A single control word selects between two access styles. The first is a paged register access of the kind defined in IEEE 802.3 Clause 22, which is preceded by a page-select write. The second is an indirect MMD access of the kind defined in Clause 45, made of an address frame followed by a data frame. Reads target one port, and the result lands in the low half of the data word. Writes take their value from the high half of the data word and go to every port whose bit is set in the port mask, lowest port first.

The MDIO master drives MDIO while MDC is low and samples it on the rising edge. MDC comes from a parameterised divider of the system clock.

Top module: `mdio_cmd_unit`

## Requirements
- R1: After reset every register reads zero, MDC is low and MDIO is not driven.
- R2: Control word layout: bit 0 is execute/busy, bit 1 is the error flag, bit 2 selects an MMD access, bit 3 selects a write, bits 9:5 hold the register number and bits 22:10 hold the page. Writing the control word (address 0) with bit 0 set while idle starts a transaction. Bit 0 reads 1 from the next cycle until the transaction is complete, then returns to 0.
- R3: A paged access to a port first sends a Clause-22 write (start 01, opcode 01) to register 31 carrying the page number. It then sends the access itself to the chosen register, with opcode 10 for a read or 01 for a write. The PHY address is the low five bits of the port index.
- R4: When the page field equals 0x1FFF, control bits 27:23 read 0x1F and no page-select frame is sent. For any other page these bits read 0.
- R5: A read targets the port held in data word (address 1) bits 31:16. On completion the returned 16 bits appear in data bits 15:0, and bits 31:16 are unchanged.
- R6: A write sends data bits 31:16 to every port whose bit is set in the 64-bit mask. The mask's bits 31:0 are at address 3 and bits 63:32 are at address 4. Ports are visited in ascending order. An empty mask completes with no frame.
- R7: An MMD access uses the extended-address word (address 2): the device number is in bits 31:16 (its low five bits form DEVAD) and the register address is in bits 15:0. The unit sends a start-00 address frame (opcode 00) carrying the register address. It then sends a start-00 frame with opcode 11 for a read or 01 for a write.
- R8: If a read samples the second turnaround bit high (no PHY answered), error bit 1 is set and data bits 15:0 read 0xFFFF. A new launch clears the error bit.
- R9: While busy, register writes to any address are ignored.
- R10: Each frame is PRE_LEN preamble ones followed by 32 bits. One bit lasts 2*DIV clocks, with MDC low for the first DIV of them and high for the rest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 control, 1 data, 2 MMD, 3/4 mask low/high) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mdc | output | 1 | Management clock to PHYs |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line value |

## Verification
The bench builds the unit with DIV=2 and PRE_LEN=4, so a frame lasts only 144 clocks. This short frame lets a register sweep of all 32 registers, several multi-port masks, MMD accesses and absent-PHY reads fit into one short run. A bench PHY model decodes every frame on the pins, logs it and answers reads with values computed arithmetically. This allows the page-select frame, the port ordering, the raw-page skip and the turnaround error to be checked from the pins and the registers alone.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

   typedef enum logic [1:0] {
      FR_PAGE     = 2'd0,
      FR_C22      = 2'd1,
      FR_C45_ADDR = 2'd2,
      FR_C45_OP   = 2'd3
   } frame_kind_e;

   localparam logic [4:0]  PAGE_SEL_REG = 5'd31;
   localparam logic [12:0] RAW_PAGE     = 13'h1FFF;

   // 32-bit frame body: start(2) opcode(2) phy(5) reg/dev(5) turnaround(2) data(16)
   function automatic logic [31:0] mk_frame(frame_kind_e k, logic wr, logic [4:0] phy,
                                            logic [4:0] ra, logic [15:0] d);
      logic [31:0] f;
      case (k)
         FR_PAGE:     f = {2'b01, 2'b01, phy, PAGE_SEL_REG, 2'b10, d};
         FR_C22:      f = {2'b01, (wr ? 2'b01 : 2'b10), phy, ra, 2'b10, d};
         FR_C45_ADDR: f = {2'b00, 2'b00, phy, ra, 2'b10, d};
         default:     f = {2'b00, (wr ? 2'b01 : 2'b11), phy, ra, 2'b10, d};
      endcase
      return f;
   endfunction

endpackage

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine #(
   parameter int DIV     = 4,
   parameter int PRE_LEN = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        rd_req,
   input  logic [31:0] frame,
   input  logic        mdio_i,
   output logic        busy,
   output logic        done,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   output logic [15:0] rd_data,
   output logic        ta_high
);
   localparam int TOTAL = PRE_LEN + 32;
   localparam int SLOT  = 2 * DIV;
   localparam int CW    = (SLOT > 1) ? $clog2(SLOT) : 1;
   localparam int BW    = $clog2(TOTAL + 1);
   localparam logic [CW-1:0] SAMPLE_AT = CW'(DIV - 1);
   localparam logic [CW-1:0] LAST_TICK = CW'(SLOT - 1);
   localparam logic [CW-1:0] HIGH_AT   = CW'(DIV);
   localparam logic [BW-1:0] PRE_B     = BW'(PRE_LEN);
   localparam logic [BW-1:0] REL_B     = BW'(PRE_LEN + 14);
   localparam logic [BW-1:0] TA2_B     = BW'(PRE_LEN + 15);
   localparam logic [BW-1:0] DATA0_B   = BW'(PRE_LEN + 16);
   localparam logic [BW-1:0] LAST_B    = BW'(TOTAL - 1);

   logic          busy_q, rd_q, done_q, ta_q;
   logic [CW-1:0] div_q;
   logic [BW-1:0] bit_q;
   logic [31:0]   sh_q;
   logic [15:0]   cap_q;
   logic          in_pre;

   assign in_pre = bit_q < PRE_B;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         rd_q   <= 1'b0;
         done_q <= 1'b0;
         ta_q   <= 1'b0;
         div_q  <= '0;
         bit_q  <= '0;
         sh_q   <= '0;
         cap_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start) begin
               busy_q <= 1'b1;
               div_q  <= '0;
               bit_q  <= '0;
               sh_q   <= frame;
               rd_q   <= rd_req;
               cap_q  <= '0;
               ta_q   <= 1'b0;
            end
         end else begin
            if (div_q == SAMPLE_AT) begin
               if (bit_q == TA2_B)   ta_q  <= mdio_i;
               if (bit_q >= DATA0_B) cap_q <= {cap_q[14:0], mdio_i};
            end
            if (div_q == LAST_TICK) begin
               div_q <= '0;
               if (!in_pre) sh_q <= {sh_q[30:0], 1'b0};
               if (bit_q == LAST_B) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  bit_q <= bit_q + 1'b1;
               end
            end else begin
               div_q <= div_q + 1'b1;
            end
         end
      end
   end

   assign busy    = busy_q;
   assign done    = done_q;
   assign mdc     = busy_q && (div_q >= HIGH_AT);
   assign mdio_o  = in_pre ? 1'b1 : sh_q[31];
   assign mdio_oe = busy_q && (!rd_q || (bit_q < REL_B));
   assign rd_data = cap_q;
   assign ta_high = ta_q;

   // R10: the pin value only moves at the start of a bit, never while MDC is high
   p_stable_mdc_high_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && mdc) |=> (!busy_q || !mdc || $stable(mdio_o)));

   // R10: completion follows a busy frame
   p_done_after_frame_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (!busy_q && $past(busy_q)));
endmodule

// File: rtl/mdio_access_seq.sv
module mdio_access_seq
   import mdio_pkg::*;
#(
   parameter int PORTS = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic             is_mmd,
   input  logic             is_write,
   input  logic             raw,
   input  logic [4:0]       reg_num,
   input  logic [12:0]      page,
   input  logic [4:0]       mmd_dev,
   input  logic [15:0]      mmd_reg,
   input  logic [15:0]      wdata,
   input  logic [PORTS-1:0] mask,
   input  logic [4:0]       rd_phy,
   output logic             busy,
   output logic             fin,
   output logic [15:0]      rd_result,
   output logic             rd_err,
   output logic             eng_start,
   output logic [31:0]      eng_frame,
   output logic             eng_rd,
   input  logic             eng_done,
   input  logic [15:0]      eng_data,
   input  logic             eng_ta
);
   localparam int PW = $clog2(PORTS) + 1;

   typedef enum logic [2:0] {S_IDLE, S_PICK, S_ISSUE, S_WAIT, S_FIN} st_e;

   st_e           st_q;
   logic [PW-1:0] cur_q, prev_q, found_idx;
   logic          step_q, had_q, found, last;
   logic [15:0]   res_q, dat;
   logic          err_q;
   logic [4:0]    phy, ra;
   logic [PORTS-1:0] avail;
   frame_kind_e   kind;

   // lowest set mask bit at or above the current port
   assign avail = mask & ({PORTS{1'b1}} << cur_q);
   always_comb begin
      found     = 1'b0;
      found_idx = '0;
      for (int i = PORTS - 1; i >= 0; i--) begin
         if (avail[i]) begin
            found     = 1'b1;
            found_idx = PW'(i);
         end
      end
   end

   assign last = step_q || (!is_mmd && raw);
   assign phy  = is_write ? 5'(cur_q) : rd_phy;

   always_comb begin
      if (is_mmd) kind = step_q ? FR_C45_OP : FR_C45_ADDR;
      else        kind = (step_q || raw) ? FR_C22 : FR_PAGE;
      case (kind)
         FR_PAGE:     begin dat = {3'b000, page};              ra = PAGE_SEL_REG; end
         FR_C22:      begin dat = is_write ? wdata : 16'hFFFF; ra = reg_num;      end
         FR_C45_ADDR: begin dat = mmd_reg;                     ra = mmd_dev;      end
         default:     begin dat = is_write ? wdata : 16'hFFFF; ra = mmd_dev;      end
      endcase
   end

   assign eng_frame = mk_frame(kind, is_write, phy, ra, dat);
   assign eng_rd    = !is_write && last;
   assign eng_start = (st_q == S_ISSUE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         cur_q  <= '0;
         prev_q <= '0;
         step_q <= 1'b0;
         had_q  <= 1'b0;
         res_q  <= '0;
         err_q  <= 1'b0;
      end else begin
         case (st_q)
            S_IDLE: if (launch) begin
               step_q <= 1'b0;
               had_q  <= 1'b0;
               cur_q  <= '0;
               st_q   <= is_write ? S_PICK : S_ISSUE;
            end
            S_PICK: if (found) begin
               cur_q  <= found_idx;
               prev_q <= found_idx;
               had_q  <= 1'b1;
               step_q <= 1'b0;
               st_q   <= S_ISSUE;
            end else begin
               st_q <= S_FIN;
            end
            S_ISSUE: st_q <= S_WAIT;
            S_WAIT: if (eng_done) begin
               if (!last) begin
                  step_q <= 1'b1;
                  st_q   <= S_ISSUE;
               end else if (is_write) begin
                  cur_q <= cur_q + 1'b1;
                  st_q  <= S_PICK;
               end else begin
                  res_q <= eng_data;
                  err_q <= eng_ta;
                  st_q  <= S_FIN;
               end
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign busy      = (st_q != S_IDLE);
   assign fin       = (st_q == S_FIN);
   assign rd_result = res_q;
   assign rd_err    = err_q;

   // R6: ports of one write are visited in strictly ascending order
   p_ports_ascending_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_PICK && found && had_q) |-> (found_idx > prev_q));

   // R4: a raw-page read sends only the read frame itself
   p_raw_single_frame_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (eng_start && raw && !is_mmd && !is_write) |-> eng_rd);

   // R7: the first frame of an MMD access is an address frame
   p_mmd_addr_first_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (eng_start && is_mmd && !step_q) |-> (eng_frame[31:28] == 4'b0000));
endmodule

// File: rtl/mdio_cmd_unit.sv
module mdio_cmd_unit
   import mdio_pkg::*;
#(
   parameter int DIV     = 4,
   parameter int PRE_LEN = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [2:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   localparam int MASK_W     = 64;
   localparam int MASK_WORDS = MASK_W / 32;
   localparam logic [2:0] ADR_CTRL  = 3'd0;
   localparam logic [2:0] ADR_DATA  = 3'd1;
   localparam logic [2:0] ADR_MMD   = 3'd2;
   localparam int         ADR_MASK0 = 3;

   if (DIV < 1) begin : g_bad_div
      $error("DIV must be at least 1");
   end
   if (PRE_LEN < 1 || PRE_LEN > 64) begin : g_bad_pre
      $error("PRE_LEN must be within 1..64");
   end

   logic [4:0]        reg_q;
   logic [12:0]       page_q;
   logic              mmd_q, wr_q, err_q, launch_q;
   logic [31:0]       data_q, mmdw_q;
   logic [MASK_W-1:0] mask_q;
   logic              busy, seq_busy, seq_fin, seq_err, raw, launch, wr_ok;
   logic [15:0]       seq_res, eng_data;
   logic              eng_start, eng_rd, eng_done, eng_busy, eng_ta;
   logic [31:0]       eng_frame;

   assign busy   = launch_q | seq_busy;
   assign wr_ok  = reg_we && !busy;
   assign launch = wr_ok && (reg_addr == ADR_CTRL) && reg_wdata[0];
   assign raw    = (page_q == RAW_PAGE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_q    <= '0;
         page_q   <= '0;
         mmd_q    <= 1'b0;
         wr_q     <= 1'b0;
         err_q    <= 1'b0;
         launch_q <= 1'b0;
         data_q   <= '0;
         mmdw_q   <= '0;
      end else begin
         launch_q <= launch;
         if (wr_ok && reg_addr == ADR_CTRL) begin
            reg_q  <= reg_wdata[9:5];
            page_q <= reg_wdata[22:10];
            mmd_q  <= reg_wdata[2];
            wr_q   <= reg_wdata[3];
         end
         if (launch) err_q <= 1'b0;
         if (wr_ok && reg_addr == ADR_DATA) data_q <= reg_wdata;
         if (wr_ok && reg_addr == ADR_MMD)  mmdw_q <= reg_wdata;
         if (seq_fin && !wr_q) begin
            data_q[15:0] <= seq_res;
            err_q        <= seq_err;
         end
      end
   end

   for (genvar w = 0; w < MASK_WORDS; w++) begin : g_mask
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mask_q[w*32 +: 32] <= '0;
         else if (wr_ok && reg_addr == 3'(ADR_MASK0 + w))
            mask_q[w*32 +: 32] <= reg_wdata;
      end
   end

   always_comb begin
      case (reg_addr)
         ADR_CTRL: reg_rdata = {4'b0000, (raw ? 5'h1F : 5'h00), page_q, reg_q,
                                1'b0, wr_q, mmd_q, err_q, busy};
         ADR_DATA: reg_rdata = data_q;
         ADR_MMD:  reg_rdata = mmdw_q;
         3'd3:     reg_rdata = mask_q[31:0];
         3'd4:     reg_rdata = mask_q[63:32];
         default:  reg_rdata = '0;
      endcase
   end

   mdio_access_seq #(.PORTS(MASK_W)) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch_q),
      .is_mmd    (mmd_q),
      .is_write  (wr_q),
      .raw       (raw),
      .reg_num   (reg_q),
      .page      (page_q),
      .mmd_dev   (mmdw_q[20:16]),
      .mmd_reg   (mmdw_q[15:0]),
      .wdata     (data_q[31:16]),
      .mask      (mask_q),
      .rd_phy    (data_q[20:16]),
      .busy      (seq_busy),
      .fin       (seq_fin),
      .rd_result (seq_res),
      .rd_err    (seq_err),
      .eng_start (eng_start),
      .eng_frame (eng_frame),
      .eng_rd    (eng_rd),
      .eng_done  (eng_done),
      .eng_data  (eng_data),
      .eng_ta    (eng_ta)
   );

   mdio_frame_engine #(.DIV(DIV), .PRE_LEN(PRE_LEN)) eng_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (eng_start),
      .rd_req  (eng_rd),
      .frame   (eng_frame),
      .mdio_i  (mdio_i),
      .busy    (eng_busy),
      .done    (eng_done),
      .mdc     (mdc),
      .mdio_o  (mdio_o),
      .mdio_oe (mdio_oe),
      .rd_data (eng_data),
      .ta_high (eng_ta)
   );

   // R9: MMD word holds while a transaction runs
   p_hold_while_busy_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_we && reg_addr == ADR_MMD) |=> $stable(mmdw_q));

   // R2: execute reads busy right after a launch
   p_busy_after_launch_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> busy);

   // R8: a new launch starts with a clear error flag
   p_err_clear_launch_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> !err_q);

   // R10: no frame activity while the sequencer is idle
   p_engine_idle_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      !seq_busy |-> !eng_busy);
endmodule

// File: tb/mdio_cmd_unit_tb_top.sv
module mdio_cmd_unit_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DIV_T      = 2;
   localparam int PRE_T      = 4;
   localparam int N_PRESENT  = 6;

   logic        clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        resp_oe = 1'b0, resp_val = 1'b1;
   logic        mdio_line;

   assign mdio_line = mdio_oe ? mdio_o : (resp_oe ? resp_val : 1'b1);

   mdio_cmd_unit #(.DIV(DIV_T), .PRE_LEN(PRE_T)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line));

   always #(CLK_PERIOD / 2) clk = ~clk;

   int n_chk = 0, n_err = 0;

   // ---------------- PHY model ----------------
   int          bits = -1;
   logic [31:0] fr;
   logic        rd_act = 1'b0;
   logic [15:0] rv;
   logic [12:0] pg    [32];
   logic [4:0]  mdev  [32];
   logic [15:0] maddr [32];
   logic [15:0] m22 [int];
   logic [15:0] m45 [int];
   int          fcnt = 0;
   logic [31:0] log_fr [64];
   int          rises = 0;
   time         last_rise = 0, mdc_period = 0;

   function automatic int k22(int phy, int page, int ra);
      return phy * 262144 + page * 32 + ra;
   endfunction
   function automatic int k45(int phy, int dev, int adr);
      return phy * 2097152 + dev * 65536 + adr;
   endfunction
   function automatic logic [15:0] d22(logic [4:0] phy, logic [12:0] page, logic [4:0] ra);
      return 16'hA5A5 ^ {phy, ra, page[5:0]};
   endfunction
   function automatic logic [15:0] d45(logic [4:0] phy, logic [4:0] dev, logic [15:0] adr);
      return 16'h5A5A ^ adr ^ {phy, dev, 6'b0};
   endfunction

   initial begin
      for (int i = 0; i < 32; i++) begin
         pg[i] = '0; mdev[i] = '0; maddr[i] = '0;
      end
   end

   always @(posedge mdc) begin
      rises++;
      mdc_period = $time - last_rise;
      last_rise  = $time;
      if (bits < 0) begin
         if (mdio_line == 1'b0) begin
            fr   = '0;
            bits = 1;
         end
      end else begin
         fr   = {fr[30:0], mdio_line};
         bits = bits + 1;
      end
      if (bits == 14) begin
         logic [4:0] p, r;
         p = fr[9:5];
         r = fr[4:0];
         rd_act = (p < N_PRESENT) &&
                  ((fr[13:12] == 2'b01 && fr[11:10] == 2'b10) ||
                   (fr[13:12] == 2'b00 && fr[11:10] == 2'b11));
         if (fr[13:12] == 2'b01)
            rv = m22.exists(k22(p, pg[p], r)) ? m22[k22(p, pg[p], r)] : d22(p, pg[p], r);
         else
            rv = m45.exists(k45(p, mdev[p], maddr[p])) ? m45[k45(p, mdev[p], maddr[p])]
                                                       : d45(p, mdev[p], maddr[p]);
      end
      if (bits == 32) begin
         logic [4:0] p, r;
         p = fr[27:23];
         r = fr[22:18];
         if (p < N_PRESENT) begin
            if (fr[31:28] == 4'b0101) begin
               if (r == 5'd31) pg[p] = fr[12:0];
               else m22[k22(p, pg[p], r)] = fr[15:0];
            end else if (fr[31:28] == 4'b0000) begin
               mdev[p] = r; maddr[p] = fr[15:0];
            end else if (fr[31:28] == 4'b0001) begin
               m45[k45(p, mdev[p], maddr[p])] = fr[15:0];
            end
         end
         log_fr[fcnt % 64] = fr;
         fcnt   = fcnt + 1;
         bits   = -1;
         rd_act = 1'b0;
      end
   end

   always @(negedge mdc) begin
      if (rd_act && bits >= 15 && bits <= 31) begin
         resp_oe  = 1'b1;
         resp_val = (bits == 15) ? 1'b0 : rv[31 - bits];
      end else begin
         resp_oe = 1'b0;
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_idle(input string tag);
      logic [31:0] c;
      int n;
      n = 0;
      do begin
         rd(3'd0, c);
         n++;
      end while (c[0] && n < 20000);
      if (c[0]) chk({tag, " busy timeout"}, 32'd1, 32'd0);
   endtask

   function automatic logic [31:0] ctl(logic mmd, logic w, logic [12:0] page, logic [4:0] r);
      return {9'b0, page, r, 1'b0, w, mmd, 1'b0, 1'b1};
   endfunction

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      logic [31:0] v;
      int f0, r0;

      repeat (4) @(negedge clk);
      for (int a = 0; a < 5; a++) begin
         rd(3'(a), v);
         chk("R1 reset register", v, 32'h0);
      end
      chk("R1 reset mdc", {31'b0, mdc}, 32'd0);
      chk("R1 reset oe", {31'b0, mdio_oe}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R3/R5/R2/R10: paged read sweep over all registers
      wr(3'd1, {16'd1, 16'h0});
      for (int r = 0; r < 32; r++) begin
         f0 = fcnt; r0 = rises;
         wr(3'd0, ctl(1'b0, 1'b0, 13'd3, 5'(r)));
         if (r == 0) begin
            rd(3'd0, v);
            chk("R2 busy after launch", {31'b0, v[0]}, 32'd1);
         end
         wait_idle("R2");
         rd(3'd1, v);
         chk("R5 paged read data", v, {16'd1, d22(5'd1, 13'd3, 5'(r))});
         chk("R3 two frames", 32'(fcnt - f0), 32'd2);
         if (r == 5) begin
            chk("R3 page select frame", log_fr[f0 % 64], {4'b0101, 5'd1, 5'd31, 2'b10, 16'd3});
            chk("R3 read access header", {18'b0, log_fr[(f0 + 1) % 64][31:18]},
                {18'b0, 4'b0110, 5'd1, 5'd5});
            chk("R10 mdc edges", 32'(rises - r0), 32'(2 * (PRE_T + 32)));
            chk("R10 mdc period", 32'(mdc_period), 32'(2 * DIV_T * CLK_PERIOD));
            rd(3'd0, v);
            chk("R8 error clear", {31'b0, v[1]}, 32'd0);
         end
      end

      // R6: multi-port write, ascending
      wr(3'd3, 32'h0000_001A);
      wr(3'd4, 32'h0);
      wr(3'd1, {16'h1234, 16'h0});
      f0 = fcnt;
      wr(3'd0, ctl(1'b0, 1'b1, 13'd7, 5'd9));
      wait_idle("R6");
      chk("R6 frame count", 32'(fcnt - f0), 32'd6);
      chk("R6 order 1st", {27'b0, log_fr[(f0 + 1) % 64][27:23]}, 32'd1);
      chk("R6 order 2nd", {27'b0, log_fr[(f0 + 3) % 64][27:23]}, 32'd3);
      chk("R6 order 3rd", {27'b0, log_fr[(f0 + 5) % 64][27:23]}, 32'd4);
      rd(3'd0, v);
      chk("R4 normal page flag", {27'b0, v[27:23]}, 32'd0);
      for (int p = 1; p < 5; p++) begin
         wr(3'd1, {16'(p), 16'h0});
         wr(3'd0, ctl(1'b0, 1'b0, 13'd7, 5'd9));
         wait_idle("R6");
         rd(3'd1, v);
         chk("R6 readback", v[15:0], (p == 2) ? d22(5'd2, 13'd7, 5'd9) : 16'h1234);
      end

      // R6: lowest and highest mask bits
      wr(3'd3, 32'h0000_0001);
      wr(3'd4, 32'h8000_0000);
      wr(3'd1, {16'h0BAD, 16'h0});
      f0 = fcnt;
      wr(3'd0, ctl(1'b0, 1'b1, 13'd2, 5'd4));
      wait_idle("R6");
      chk("R6 edge frame count", 32'(fcnt - f0), 32'd4);
      chk("R6 edge order first", {27'b0, log_fr[(f0 + 1) % 64][27:23]}, 32'd0);
      chk("R6 edge order last", {27'b0, log_fr[(f0 + 3) % 64][27:23]}, 32'd31);

      // R6: empty mask
      wr(3'd3, 32'h0);
      wr(3'd4, 32'h0);
      f0 = fcnt;
      wr(3'd0, ctl(1'b0, 1'b1, 13'd2, 5'd4));
      wait_idle("R6");
      chk("R6 empty mask no frames", 32'(fcnt - f0), 32'd0);

      // R4: raw page
      wr(3'd1, {16'd1, 16'h0});
      f0 = fcnt;
      wr(3'd0, ctl(1'b0, 1'b0, 13'h1FFF, 5'd9));
      rd(3'd0, v);
      chk("R4 raw page flag", {27'b0, v[27:23]}, 32'h1F);
      wait_idle("R4");
      chk("R4 single frame", 32'(fcnt - f0), 32'd1);
      rd(3'd1, v);
      chk("R4 raw read uses current page", v, {16'd1, 16'h1234});

      // R7: MMD write then read
      wr(3'd2, {16'd7, 16'h003C});
      wr(3'd3, 32'h0000_0004);
      wr(3'd1, {16'hBEEF, 16'h0});
      f0 = fcnt;
      wr(3'd0, ctl(1'b1, 1'b1, 13'd0, 5'd0));
      wait_idle("R7");
      chk("R7 frame count", 32'(fcnt - f0), 32'd2);
      chk("R7 address frame", log_fr[f0 % 64], {4'b0000, 5'd2, 5'd7, 2'b10, 16'h003C});
      chk("R7 write frame", log_fr[(f0 + 1) % 64], {4'b0001, 5'd2, 5'd7, 2'b10, 16'hBEEF});
      wr(3'd1, {16'd2, 16'h0});
      f0 = fcnt;
      wr(3'd0, ctl(1'b1, 1'b0, 13'd0, 5'd0));
      wait_idle("R7");
      rd(3'd1, v);
      chk("R7 mmd readback", v, {16'd2, 16'hBEEF});
      chk("R7 read opcode", {28'b0, log_fr[(f0 + 1) % 64][31:28]}, 32'h3);
      wr(3'd2, {16'd30, 16'h1234});
      wr(3'd1, {16'd4, 16'h0});
      wr(3'd0, ctl(1'b1, 1'b0, 13'd0, 5'd0));
      wait_idle("R7");
      rd(3'd1, v);
      chk("R7 mmd default read", v, {16'd4, d45(5'd4, 5'd30, 16'h1234)});

      // R8: absent PHY
      wr(3'd1, {16'd9, 16'h0});
      wr(3'd0, ctl(1'b0, 1'b0, 13'd1, 5'd1));
      wait_idle("R8");
      rd(3'd0, v);
      chk("R8 error set", {31'b0, v[1]}, 32'd1);
      rd(3'd1, v);
      chk("R8 absent data", v, {16'd9, 16'hFFFF});
      wr(3'd1, {16'd0, 16'h0});
      wr(3'd0, ctl(1'b0, 1'b0, 13'd2, 5'd4));
      wait_idle("R8");
      rd(3'd0, v);
      chk("R8 error cleared", {31'b0, v[1]}, 32'd0);
      rd(3'd1, v);
      chk("R8 good read after error", v, {16'd0, 16'h0BAD});

      // R9: writes during busy are ignored
      wr(3'd3, 32'h0000_0004);
      wr(3'd1, {16'd2, 16'h0});
      f0 = fcnt;
      wr(3'd0, ctl(1'b0, 1'b0, 13'd3, 5'd4));
      wr(3'd2, 32'hDEAD_0000);
      wr(3'd1, {16'd5, 16'h0});
      wr(3'd3, 32'h0000_00FF);
      wr(3'd0, ctl(1'b0, 1'b1, 13'd9, 5'd9));
      wait_idle("R9");
      rd(3'd2, v);
      chk("R9 mmd word kept", v, {16'd30, 16'h1234});
      rd(3'd3, v);
      chk("R9 mask kept", v, 32'h0000_0004);
      rd(3'd1, v);
      chk("R9 data from launched read", v, {16'd2, d22(5'd2, 13'd3, 5'd4)});
      rd(3'd0, v);
      chk("R9 control fields kept", {14'b0, v[22:5]}, {14'b0, 13'd3, 5'd4});
      chk("R9 write bit kept", {31'b0, v[3]}, 32'd0);
      chk("R9 no extra frames", 32'(fcnt - f0), 32'd2);

      summary();
      $finish;
   end
endmodule